// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block derives the serial clock of an I2C master from the system clock. An 8-bit period value sets the length of a time unit: each unit lasts 2*(1+P) system clocks, where P is the programmed value. One SCL period is ten units. SCL is held low for the first six units and released high for the last four, so a period spans 20*(1+P) system clocks, with 12*(1+P) of them low and 8*(1+P) high. The block emits a one-cycle phase strobe at the end of every unit. Other parts of the master can use that strobe to place their own events on the SCL timeline.

A small word-wide register port holds the period value, an 8-bit data byte, an interrupt enable bit and a pending-event bit. An event input sets the pending bit. Software clears it by writing. The interrupt output is the pending bit gated by the enable bit. When the run input is low, SCL idles high and all timing state is held at zero. A period value written while SCL is running is applied only at the next period boundary, so no unit of the current period is cut short.

Top module: `sclgen_top`

## Requirements
- R1: After reset the period register reads 1, the data, enable and pending registers read 0, sclOut is 1 and irqOut is 0.
- R2: While running, phaseStrobe pulses high for exactly one cycle at the end of every time unit of 2*(1+P) clocks. This gives ten pulses per SCL period.
- R3: While running, sclOut is low for 12*(1+P) clocks and then high for 8*(1+P) clocks, repeating. It goes low in the same cycle that runEn rises.
- R4: A new period value written while running leaves the current SCL period unchanged and is used from the next period on.
- R5: With runEn low, sclOut is 1 and the unit and phase counters are held at zero, so every enable starts with a full low phase.
- R6: Register map on regAddr: 0 holds the data byte in bits 7:0, 1 holds the period in bits 7:0, 2 holds the interrupt enable in bit 0, and 3 reads the pending bit in bit 0. Bits above each field read as 0 and ignore writes.
- R7: rawEvent sets the pending bit. A write to address 3 with bit 0 set clears it, and a write with bit 0 clear leaves it unchanged. When an event and a clear arrive in the same cycle, the pending bit ends up set.
- R8: irqOut is 1 exactly when the pending bit and the interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the selected register, combinational |
| runEn | input | 1 | Enables SCL generation |
| rawEvent | input | 1 | Sets the pending interrupt bit |
| sclOut | output | 1 | Generated SCL level |
| phaseStrobe | output | 1 | One-cycle pulse at the end of each time unit |
| irqOut | output | 1 | Pending bit gated by the interrupt enable |

## Verification
SCL is run with period values 1, 4 and 255. Matching low and high lengths across these values show that the unit length scales with 1+P and that the 6:4 split is kept, not just fixed at one setting. A run in which the period changes from 1 to 3 during the first low phase separates an update at the period boundary from an immediate update. There the first period stays at 24/16 clocks and the next low phase becomes 48. Repeated disable and enable, with each run cut off partway through a high phase, show that each enable starts from a full low phase. The register and interrupt patterns cover set-only, masked, unmasked, a clear with bit 0 at zero, and an event arriving together with a clear.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_DATA   = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_MASK   = 2'd2,
    ADDR_STATUS = 2'd3
  } regAddr_e;

  // Control to datapath strobes
  typedef struct packed {
    logic run;     // counters advance
    logic reload;  // capture new period value
  } ctrlStb_t;

  // Datapath to control strobes
  typedef struct packed {
    logic tick;       // end of a time unit
    logic periodEnd;  // end of the last unit of an SCL period
  } dpStat_t;

endpackage

// File: rtl/sclgen_datapath.sv
module sclgen_datapath
  import sclgen_pkg::*;
#(
  parameter int TPR_W      = 8,
  parameter int LOW_UNITS  = 6,
  parameter int HIGH_UNITS = 4,
  parameter int TPR_RESET  = 1,
  parameter int PHASE_W    = $clog2(LOW_UNITS + HIGH_UNITS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           ctrlStb,
  input  logic [TPR_W-1:0]   tprIn,
  output dpStat_t            dpStat,
  output logic [PHASE_W-1:0] phaseCnt,
  output logic               sclOut
);

  localparam int PERIOD_UNITS = LOW_UNITS + HIGH_UNITS;
  localparam int PRE_W        = TPR_W + 1;

  logic [TPR_W-1:0] activeTpr;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             tick;
  logic             lastPhase;

  // 2*(1+P)-1 == 2P+1
  assign preLimit  = {activeTpr, 1'b1};
  assign tick      = ctrlStb.run && (preCnt == preLimit);
  assign lastPhase = (phaseCnt == PHASE_W'(PERIOD_UNITS - 1));

  assign dpStat.tick      = tick;
  assign dpStat.periodEnd = tick && lastPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeTpr <= TPR_W'(TPR_RESET);
    end else if (ctrlStb.reload) begin
      activeTpr <= tprIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      phaseCnt <= '0;
    end else if (!ctrlStb.run) begin
      preCnt   <= '0;
      phaseCnt <= '0;
    end else if (tick) begin
      preCnt   <= '0;
      phaseCnt <= lastPhase ? '0 : phaseCnt + 1'b1;
    end else begin
      preCnt   <= preCnt + 1'b1;
    end
  end

  assign sclOut = !(ctrlStb.run && (phaseCnt < PHASE_W'(LOW_UNITS)));

endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
  import sclgen_pkg::*;
#(
  parameter int TPR_W     = 8,
  parameter int DATA_W    = 8,
  parameter int BUS_W     = 32,
  parameter int TPR_RESET = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]      regWrData,
  output logic [BUS_W-1:0]      regRdData,
  input  logic                  runEn,
  input  logic                  rawEvent,
  input  dpStat_t               dpStat,
  output ctrlStb_t              ctrlStb,
  output logic [TPR_W-1:0]      tprOut,
  output logic                  phaseStrobe,
  output logic                  rawPend,
  output logic                  irqMask,
  output logic                  irqOut
);

  localparam int USED_W = (DATA_W > TPR_W) ? DATA_W : TPR_W;

  logic [DATA_W-1:0] dataReg;
  logic [TPR_W-1:0]  tprReg;
  logic              clearHit;
  logic              unusedWrHigh;
  regAddr_e          addrSel;

  assign addrSel      = regAddr_e'(regAddr);
  assign unusedWrHigh = ^regWrData[BUS_W-1:USED_W];
  assign clearHit     = regWrEn && (addrSel == ADDR_STATUS) && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      tprReg  <= TPR_W'(TPR_RESET);
      irqMask <= 1'b0;
    end else if (regWrEn) begin
      unique case (addrSel)
        ADDR_DATA:   dataReg <= regWrData[DATA_W-1:0];
        ADDR_PERIOD: tprReg  <= regWrData[TPR_W-1:0];
        ADDR_MASK:   irqMask <= regWrData[0];
        default:     ;
      endcase
    end
  end

  // Set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawPend <= 1'b0;
    end else if (rawEvent) begin
      rawPend <= 1'b1;
    end else if (clearHit) begin
      rawPend <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (addrSel)
      ADDR_DATA:   regRdData[DATA_W-1:0] = dataReg;
      ADDR_PERIOD: regRdData[TPR_W-1:0]  = tprReg;
      ADDR_MASK:   regRdData[0]          = irqMask;
      ADDR_STATUS: regRdData[0]          = rawPend;
      default:     ;
    endcase
  end

  assign ctrlStb.run    = runEn;
  assign ctrlStb.reload = !runEn || dpStat.periodEnd;
  assign tprOut         = tprReg;
  assign phaseStrobe    = runEn && dpStat.tick;
  assign irqOut         = rawPend && irqMask;

endmodule

// File: rtl/sclgen_top.sv
module sclgen_top
  import sclgen_pkg::*;
#(
  parameter int TPR_W      = 8,
  parameter int DATA_W     = 8,
  parameter int BUS_W      = 32,
  parameter int LOW_UNITS  = 6,
  parameter int HIGH_UNITS = 4,
  parameter int TPR_RESET  = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]      regWrData,
  output logic [BUS_W-1:0]      regRdData,
  input  logic                  runEn,
  input  logic                  rawEvent,
  output logic                  sclOut,
  output logic                  phaseStrobe,
  output logic                  irqOut
);

  localparam int PERIOD_UNITS = LOW_UNITS + HIGH_UNITS;
  localparam int PHASE_W      = $clog2(PERIOD_UNITS);

  ctrlStb_t           ctrlStb;
  dpStat_t            dpStat;
  logic [TPR_W-1:0]   tprVal;
  logic [PHASE_W-1:0] phaseCnt;
  logic               rawPend;
  logic               irqMask;

  sclgen_ctrl #(
    .TPR_W    (TPR_W),
    .DATA_W   (DATA_W),
    .BUS_W    (BUS_W),
    .TPR_RESET(TPR_RESET)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .runEn      (runEn),
    .rawEvent   (rawEvent),
    .dpStat     (dpStat),
    .ctrlStb    (ctrlStb),
    .tprOut     (tprVal),
    .phaseStrobe(phaseStrobe),
    .rawPend    (rawPend),
    .irqMask    (irqMask),
    .irqOut     (irqOut)
  );

  sclgen_datapath #(
    .TPR_W     (TPR_W),
    .LOW_UNITS (LOW_UNITS),
    .HIGH_UNITS(HIGH_UNITS),
    .TPR_RESET (TPR_RESET),
    .PHASE_W   (PHASE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlStb (ctrlStb),
    .tprIn   (tprVal),
    .dpStat  (dpStat),
    .phaseCnt(phaseCnt),
    .sclOut  (sclOut)
  );

endmodule

// File: rtl/sclgen_checker.sv
module sclgen_checker #(
  parameter int PERIOD_UNITS = 10,
  parameter int PHASE_W      = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               runEn,
  input logic               rawEvent,
  input logic               regWrEn,
  input logic               sclOut,
  input logic               phaseStrobe,
  input logic               irqOut,
  input logic               rawPend,
  input logic               irqMask,
  input logic [PHASE_W-1:0] phaseCnt
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    phaseStrobe |=> !phaseStrobe); // R2

  AST_SCL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !phaseStrobe) |=> (!runEn || $stable(sclOut))); // R3

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt < PHASE_W'(PERIOD_UNITS)); // R3

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> sclOut); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (phaseCnt == '0)); // R5

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    rawEvent |=> rawPend); // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (rawEvent && irqMask && !regWrEn) |=> irqOut); // R8

endmodule

bind sclgen_top sclgen_checker #(
  .PERIOD_UNITS(PERIOD_UNITS),
  .PHASE_W     (PHASE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .runEn      (runEn),
  .rawEvent   (rawEvent),
  .regWrEn    (regWrEn),
  .sclOut     (sclOut),
  .phaseStrobe(phaseStrobe),
  .irqOut     (irqOut),
  .rawPend    (rawPend),
  .irqMask    (irqMask),
  .phaseCnt   (phaseCnt)
);

// File: tb/test_sclgen_top.sv
`timescale 1ns/1ps
module test_sclgen_top;

  typedef struct {
    logic  level;
    int    len;
    string tag;
  } runItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        runEn = 1'b0;
  logic        rawEvent = 1'b0;
  logic        sclOut;
  logic        phaseStrobe;
  logic        irqOut;

  int       checks = 0;
  int       errors = 0;
  int       strobeSeen = 0;
  bit       finished = 1'b0;
  runItem_t expQ[$];

  always #4 clk = ~clk;

  sclgen_top i_sclgen_top (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .runEn      (runEn),
    .rawEvent   (rawEvent),
    .sclOut     (sclOut),
    .phaseStrobe(phaseStrobe),
    .irqOut     (irqOut)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdCheck(input logic [1:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  // Monitor: measures SCL run lengths and compares them with the queue
  logic trackOn = 1'b0;
  logic curLvl = 1'b1;
  int   runLen = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rstN || !runEn) begin
        trackOn = 1'b0;
      end else begin
        if (phaseStrobe) strobeSeen++;
        if (!trackOn) begin
          trackOn = 1'b1;
          curLvl  = sclOut;
          runLen  = 1;
        end else if (sclOut != curLvl) begin
          if (expQ.size() == 0) begin
            checks++; errors++;
            $display("FAIL R3: unexpected SCL edge, actual level %0d len %0d expected none",
                     curLvl, runLen);
          end else begin
            runItem_t it;
            it = expQ.pop_front();
            check({it.tag, " level"}, curLvl, it.level);
            check({it.tag, " length"}, runLen, it.len);
          end
          curLvl = sclOut;
          runLen = 1;
        end else begin
          runLen++;
        end
      end
    end
  end

  // Driver: run n periods at fixed period value, cut off inside last high phase
  task automatic runFixed(input int tpr, input int n);
    int u;
    u = 2 * (1 + tpr);
    wrReg(2'd1, 32'(tpr));
    for (int p = 0; p < n; p++) begin
      expQ.push_back('{1'b0, 6 * u, (p == 0) ? "R5" : "R3"});
      if (p < n - 1) expQ.push_back('{1'b1, 4 * u, "R3"});
    end
    strobeSeen = 0;
    @(posedge clk); #1;
    runEn = 1'b1;
    repeat ((10 * n - 2) * u) @(posedge clk);
    #1;
    runEn = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R3 all runs seen", expQ.size(), 0);
    check("R2 strobe count", strobeSeen, 10 * n - 2);
    check("R5 idle high", sclOut, 1);
  endtask

  // Driver: period value changes from 1 to 3 during first low phase
  task automatic runChange();
    wrReg(2'd1, 32'd1);
    expQ.push_back('{1'b0, 24, "R4"});
    expQ.push_back('{1'b1, 16, "R4"});
    expQ.push_back('{1'b0, 48, "R4"});
    @(posedge clk); #1;
    runEn = 1'b1;
    repeat (3) @(posedge clk);
    wrReg(2'd1, 32'd3);
    repeat (104 - 5) @(posedge clk);
    #1;
    runEn = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R4 all runs seen", expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rdCheck(2'd0, 32'h0, "R1 data reset");
    rdCheck(2'd1, 32'h1, "R1 period reset");
    rdCheck(2'd2, 32'h0, "R1 mask reset");
    rdCheck(2'd3, 32'h0, "R1 pending reset");
    check("R1 scl reset", sclOut, 1);
    check("R1 irq reset", irqOut, 0);

    // R6 field widths
    wrReg(2'd0, 32'hFFFF_FFA5);
    rdCheck(2'd0, 32'h0000_00A5, "R6 data byte");
    wrReg(2'd1, 32'h00AB_CD12);
    rdCheck(2'd1, 32'h0000_0012, "R6 period byte");
    wrReg(2'd2, 32'hFFFF_FFFE);
    rdCheck(2'd2, 32'h0, "R6 mask bit0");
    wrReg(2'd3, 32'hFFFF_FFFF);
    rdCheck(2'd3, 32'h0, "R6 status not writable");

    // R7 and R8 interrupt
    @(posedge clk); #1 rawEvent = 1'b1;
    @(posedge clk); #1 rawEvent = 1'b0;
    rdCheck(2'd3, 32'h1, "R7 event sets");
    check("R8 masked irq", irqOut, 0);
    wrReg(2'd2, 32'h1);
    check("R8 unmasked irq", irqOut, 1);
    wrReg(2'd3, 32'h2);
    rdCheck(2'd3, 32'h1, "R7 write bit0 zero keeps");
    wrReg(2'd3, 32'h1);
    rdCheck(2'd3, 32'h0, "R7 clear");
    check("R8 irq after clear", irqOut, 0);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 2'd3; regWrData = 32'h1; rawEvent = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0; regWrData = '0; rawEvent = 1'b0;
    rdCheck(2'd3, 32'h1, "R7 set wins");
    check("R8 irq on set win", irqOut, 1);
    wrReg(2'd3, 32'h1);
    wrReg(2'd2, 32'h0);

    // R2 R3 R5 SCL timing
    runFixed(1, 3);
    runFixed(4, 2);
    runFixed(255, 1);
    runChange();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule